// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block tracks the power state of one DRAM rank and sequences the rank into and out of power-down and self-refresh. Three paths can request entry: the read-response path when the last read returns, the precharge path when the last open bank closes, and the refresh sequencer when a refresh completes. Which low-power state is chosen depends on whether banks are still open and on the state the rank held before the refresh. Wake requests come from command issue, from work queued to a self-refreshing rank, from a drain request and from the refresh sequencer.

A wake is never scheduled earlier than a hold-off after the last entry. When a wake is accepted, the exit delay is merged into every bank's earliest column, precharge and activate cycles. The block emits one-cycle command strobes for entering and leaving each low-power state. It also accumulates the number of cycles spent in low-power states. All times are absolute values of a free-running cycle counter that starts at zero when reset is released.

Top module: `dram_rank_pwr_ctrl`

## Requirements
- R1: State codes are IDLE=0, REF=1, SREF=2, PRE_PDN=3, ACT=4, ACT_PDN=5. Reset gives IDLE with every output zero. In IDLE, `ref_start_i` moves the rank to REF and `row_open_i` moves it to ACT.
- R2: Entry is ready when neither `queued_i` nor `busy_i` is high. When `rd_last_i` is high and entry is ready, ACT goes to ACT_PDN and IDLE goes to PRE_PDN. When entry is not ready, the state is unchanged.
- R3: In ACT, `bank_closed_i` moves the rank to PRE_PDN when entry is ready, and to IDLE otherwise.
- R4: On `ref_done_i` in REF, the rank goes to IDLE if `drain_i` is high. Otherwise, when the remembered state is not IDLE, it goes to PRE_PDN if the remembered state was ACT_PDN or entry is not ready, and to SREF if neither holds. When the remembered state is IDLE, it goes to PRE_PDN if entry is ready and to IDLE if not. The remembered state is then cleared.
- R5: Every entry raises `low_pwr_o` and pulses `pd_enter_o` (with `pd_open_o` high for ACT_PDN) or `sr_enter_o`. It also sets the wake-allowed cycle to the entry edge's cycle plus HOLD_CYC. `low_pwr_o` stays high until a wake is accepted.
- R6: In PRE_PDN or ACT_PDN, `cmd_issue_i` or `ref_wake_i` wakes the rank with delay T_XP. In SREF, `queued_i` or `drain_i` wakes it with delay T_XS, and `cmd_issue_i` has no effect.
- R7: A wake accepted in cycle c uses the wake cycle w = max(c, wake-allowed). Each bank's three allowed times become max(current or same-cycle loaded value, w + delay), visible one cycle later.
- R8: A pending wake takes effect at the first edge whose cycle is at least w. ACT_PDN returns to ACT, while PRE_PDN and SREF return to IDLE.
- R9: A wake caused by `ref_wake_i` remembers the low-power state being left. Any other wake clears the remembered state to IDLE.
- R10: The exit strobe (`pd_exit_o`, or `sr_exit_o` from SREF) pulses in the cycle after acceptance, while the rank still reports its low-power state. `pd_open_o` is high with `pd_exit_o` when leaving ACT_PDN.
- R11: `idle_cyc_o` adds the number of cycles spent in SREF, PRE_PDN or ACT_PDN. It is updated two cycles after the last low-power cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_open_i | input | 1 | A bank was activated |
| rd_last_i | input | 1 | Last read response for the rank returned |
| bank_closed_i | input | 1 | Last open bank was precharged |
| ref_wake_i | input | 1 | Refresh sequencer needs the rank awake |
| ref_start_i | input | 1 | Refresh begins |
| ref_done_i | input | 1 | Refresh finished |
| cmd_issue_i | input | 1 | A read or write is issued to the rank |
| queued_i | input | 1 | Commands for the rank are queued |
| busy_i | input | 1 | Rank has outstanding scheduled events |
| drain_i | input | 1 | Drain requested |
| bank_ld_i | input | NUM_BANKS | Per-bank load of allowed times |
| col_in_i | input | NUM_BANKS*TW | Column allowed times to load |
| pre_in_i | input | NUM_BANKS*TW | Precharge allowed times to load |
| act_in_i | input | NUM_BANKS*TW | Activate allowed times to load |
| pwr_state_o | output | 3 | Current power state code |
| low_pwr_o | output | 1 | In or entering low power, no wake accepted |
| pd_enter_o | output | 1 | Power-down entry strobe |
| pd_exit_o | output | 1 | Power-down exit strobe |
| pd_open_o | output | 1 | Qualifies power-down strobes as the banks-open kind |
| sr_enter_o | output | 1 | Self-refresh entry strobe |
| sr_exit_o | output | 1 | Self-refresh exit strobe |
| col_ok_o | output | NUM_BANKS*TW | Earliest column cycle per bank |
| pre_ok_o | output | NUM_BANKS*TW | Earliest precharge cycle per bank |
| act_ok_o | output | NUM_BANKS*TW | Earliest activate cycle per bank |
| idle_cyc_o | output | TW | Total low-power residency cycles |

## Verification
State changes and entry or exit strobes appear one edge after the cycle in which the stimulus is held. Merged bank times also appear one edge after the wake is accepted. The return from a low-power state appears on the edge after the wake cycle is reached, so the low-power code is still visible in the cycle that carries the exit strobe. The residency total moves two edges after the last low-power cycle.

The bench drives on falling edges and samples one falling edge after the edge that acts. A reference cycle count and wake-allowed value, kept in the bench, give the expected bank times. The residency total is compared only after the rank has been out of low power for two cycles.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_REF     = 3'd1,
    PS_SREF    = 3'd2,
    PS_PRE_PDN = 3'd3,
    PS_ACT     = 3'd4,
    PS_ACT_PDN = 3'd5
  } pwr_state_e;

  function automatic logic is_low(input pwr_state_e s);
    return (s == PS_SREF) || (s == PS_PRE_PDN) || (s == PS_ACT_PDN);
  endfunction

endpackage

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
#(
  parameter int TW       = 16,
  parameter int T_XP     = 6,
  parameter int T_XS     = 100,
  parameter int HOLD_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] cyc_i,
  input  logic          row_open_i,
  input  logic          rd_last_i,
  input  logic          bank_closed_i,
  input  logic          ref_wake_i,
  input  logic          ref_start_i,
  input  logic          ref_done_i,
  input  logic          cmd_issue_i,
  input  logic          queued_i,
  input  logic          busy_i,
  input  logic          drain_i,
  output pwr_state_e    state_o,
  output logic          low_pwr_o,
  output logic          wake_fire_o,
  output logic [TW-1:0] wake_time_o,
  output logic          pd_enter_o,
  output logic          pd_exit_o,
  output logic          pd_open_o,
  output logic          sr_enter_o,
  output logic          sr_exit_o
);

  localparam logic [TW-1:0] XP_D = TW'(T_XP);
  localparam logic [TW-1:0] XS_D = TW'(T_XS);
  localparam logic [TW-1:0] HOLD = TW'(HOLD_CYC);

  pwr_state_e    state_q, nxt, post_q;
  logic          low_q, wk_pend_q;
  logic [TW-1:0] allow_q, wk_at_q;
  logic          entry_rdy, enter, sref_wake, pdn_wake, wake_fire, wake_due;
  logic [TW-1:0] wake_at;
  logic          pd_ent_q, pd_xit_q, pd_open_q, sr_ent_q, sr_xit_q;

  assign entry_rdy = !queued_i && !busy_i;
  assign wake_at   = (cyc_i >= allow_q) ? cyc_i : allow_q;
  assign sref_wake = (state_q == PS_SREF) && (queued_i || drain_i);
  assign pdn_wake  = ((state_q == PS_PRE_PDN) || (state_q == PS_ACT_PDN)) &&
                     (cmd_issue_i || ref_wake_i);
  assign wake_fire = low_q && !wk_pend_q && (sref_wake || pdn_wake);
  assign wake_due  = wk_pend_q && (cyc_i >= wk_at_q);

  always_comb begin
    nxt   = state_q;
    enter = 1'b0;
    case (state_q)
      PS_IDLE: begin
        if (ref_start_i) nxt = PS_REF;
        else if (rd_last_i && entry_rdy) begin
          nxt   = PS_PRE_PDN;
          enter = 1'b1;
        end else if (row_open_i) nxt = PS_ACT;
      end
      PS_ACT: begin
        if (rd_last_i && entry_rdy) begin
          nxt   = PS_ACT_PDN;
          enter = 1'b1;
        end else if (bank_closed_i) begin
          nxt   = entry_rdy ? PS_PRE_PDN : PS_IDLE;
          enter = entry_rdy;
        end
      end
      PS_REF: begin
        if (ref_done_i) begin
          if (drain_i) nxt = PS_IDLE;
          else if (post_q != PS_IDLE) begin
            nxt   = ((post_q == PS_ACT_PDN) || !entry_rdy) ? PS_PRE_PDN : PS_SREF;
            enter = 1'b1;
          end else begin
            nxt   = entry_rdy ? PS_PRE_PDN : PS_IDLE;
            enter = entry_rdy;
          end
        end
      end
      PS_PRE_PDN, PS_SREF: if (wake_due) nxt = PS_IDLE;
      PS_ACT_PDN:          if (wake_due) nxt = PS_ACT;
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_IDLE;
      post_q    <= PS_IDLE;
      low_q     <= 1'b0;
      wk_pend_q <= 1'b0;
      allow_q   <= '0;
      wk_at_q   <= '0;
      pd_ent_q  <= 1'b0;
      pd_xit_q  <= 1'b0;
      pd_open_q <= 1'b0;
      sr_ent_q  <= 1'b0;
      sr_xit_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (enter) begin
        low_q   <= 1'b1;
        allow_q <= cyc_i + HOLD;
      end
      if (wake_fire) begin
        low_q     <= 1'b0;
        wk_pend_q <= 1'b1;
        wk_at_q   <= wake_at;
        post_q    <= (pdn_wake && ref_wake_i) ? state_q : PS_IDLE;
      end else if (wake_due) begin
        wk_pend_q <= 1'b0;
      end
      if (state_q == PS_REF && ref_done_i) post_q <= PS_IDLE;
      pd_ent_q  <= enter && (nxt != PS_SREF);
      sr_ent_q  <= enter && (nxt == PS_SREF);
      pd_xit_q  <= wake_fire && (state_q != PS_SREF);
      sr_xit_q  <= wake_fire && (state_q == PS_SREF);
      pd_open_q <= (enter && nxt == PS_ACT_PDN) || (wake_fire && state_q == PS_ACT_PDN);
    end
  end

  assign state_o     = state_q;
  assign low_pwr_o   = low_q;
  assign wake_fire_o = wake_fire;
  assign wake_time_o = wake_at + (sref_wake ? XS_D : XP_D);
  assign pd_enter_o  = pd_ent_q;
  assign pd_exit_o   = pd_xit_q;
  assign pd_open_o   = pd_open_q;
  assign sr_enter_o  = sr_ent_q;
  assign sr_exit_o   = sr_xit_q;

  assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {PS_IDLE, PS_REF, PS_SREF, PS_PRE_PDN, PS_ACT, PS_ACT_PDN});

  assert_flag_tracks_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wk_pend_q |-> (low_q == is_low(state_q)));

  assert_open_exit_to_act_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == PS_ACT_PDN) && (state_q != PS_ACT_PDN) |-> state_q == PS_ACT);

  assert_closed_exit_to_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(state_q) == PS_PRE_PDN) || ($past(state_q) == PS_SREF)) && !is_low(state_q)
      |-> state_q == PS_IDLE);

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pd_ent_q, pd_xit_q, sr_ent_q, sr_xit_q}));

endmodule

// File: rtl/rank_bank_window.sv
module rank_bank_window #(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wake_fire_i,
  input  logic [TW-1:0]           wake_time_i,
  input  logic [NUM_BANKS-1:0]    ld_i,
  input  logic [NUM_BANKS*TW-1:0] col_in_i,
  input  logic [NUM_BANKS*TW-1:0] pre_in_i,
  input  logic [NUM_BANKS*TW-1:0] act_in_i,
  output logic [NUM_BANKS*TW-1:0] col_o,
  output logic [NUM_BANKS*TW-1:0] pre_o,
  output logic [NUM_BANKS*TW-1:0] act_o
);

  function automatic logic [TW-1:0] tmax(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] col_q, pre_q, act_q;
    logic [TW-1:0] col_base, pre_base, act_base;

    assign col_base = ld_i[b] ? col_in_i[b*TW +: TW] : col_q;
    assign pre_base = ld_i[b] ? pre_in_i[b*TW +: TW] : pre_q;
    assign act_base = ld_i[b] ? act_in_i[b*TW +: TW] : act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        col_q <= '0;
        pre_q <= '0;
        act_q <= '0;
      end else if (wake_fire_i) begin
        col_q <= tmax(col_base, wake_time_i);
        pre_q <= tmax(pre_base, wake_time_i);
        act_q <= tmax(act_base, wake_time_i);
      end else begin
        col_q <= col_base;
        pre_q <= pre_base;
        act_q <= act_base;
      end
    end

    assign col_o[b*TW +: TW] = col_q;
    assign pre_o[b*TW +: TW] = pre_q;
    assign act_o[b*TW +: TW] = act_q;

    assert_wake_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_fire_i |=> (col_q >= $past(wake_time_i)) && (pre_q >= $past(wake_time_i)) &&
                      (act_q >= $past(wake_time_i)));
  end

endmodule

// File: rtl/rank_lp_residency.sv
module rank_lp_residency
  import rank_pwr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pwr_state_e    state_i,
  output logic [CW-1:0] total_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] run_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      total_q <= '0;
    end else if (is_low(state_i)) begin
      run_q <= run_q + ONE;
    end else if (run_q != '0) begin
      total_q <= total_q + run_q;
      run_q   <= '0;
    end
  end

  assign total_o = total_q;

  assert_run_cleared_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_low(state_i) |=> run_q == '0);

endmodule

// File: rtl/dram_rank_pwr_ctrl.sv
module dram_rank_pwr_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 16,
  parameter int T_XP      = 6,
  parameter int T_XS      = 100,
  parameter int HOLD_CYC  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    row_open_i,
  input  logic                    rd_last_i,
  input  logic                    bank_closed_i,
  input  logic                    ref_wake_i,
  input  logic                    ref_start_i,
  input  logic                    ref_done_i,
  input  logic                    cmd_issue_i,
  input  logic                    queued_i,
  input  logic                    busy_i,
  input  logic                    drain_i,
  input  logic [NUM_BANKS-1:0]    bank_ld_i,
  input  logic [NUM_BANKS*TW-1:0] col_in_i,
  input  logic [NUM_BANKS*TW-1:0] pre_in_i,
  input  logic [NUM_BANKS*TW-1:0] act_in_i,
  output logic [2:0]              pwr_state_o,
  output logic                    low_pwr_o,
  output logic                    pd_enter_o,
  output logic                    pd_exit_o,
  output logic                    pd_open_o,
  output logic                    sr_enter_o,
  output logic                    sr_exit_o,
  output logic [NUM_BANKS*TW-1:0] col_ok_o,
  output logic [NUM_BANKS*TW-1:0] pre_ok_o,
  output logic [NUM_BANKS*TW-1:0] act_ok_o,
  output logic [TW-1:0]           idle_cyc_o
);

  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cyc_q;
  pwr_state_e    state;
  logic          wake_fire;
  logic [TW-1:0] wake_time;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + ONE;
  end

  rank_pwr_fsm #(
    .TW(TW), .T_XP(T_XP), .T_XS(T_XS), .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk_i, .rst_ni,
    .cyc_i        (cyc_q),
    .row_open_i, .rd_last_i, .bank_closed_i, .ref_wake_i, .ref_start_i,
    .ref_done_i, .cmd_issue_i, .queued_i, .busy_i, .drain_i,
    .state_o      (state),
    .low_pwr_o,
    .wake_fire_o  (wake_fire),
    .wake_time_o  (wake_time),
    .pd_enter_o, .pd_exit_o, .pd_open_o, .sr_enter_o, .sr_exit_o
  );

  rank_bank_window #(
    .NUM_BANKS(NUM_BANKS), .TW(TW)
  ) u_banks (
    .clk_i, .rst_ni,
    .wake_fire_i (wake_fire),
    .wake_time_i (wake_time),
    .ld_i        (bank_ld_i),
    .col_in_i, .pre_in_i, .act_in_i,
    .col_o       (col_ok_o),
    .pre_o       (pre_ok_o),
    .act_o       (act_ok_o)
  );

  rank_lp_residency #(
    .CW(TW)
  ) u_resid (
    .clk_i, .rst_ni,
    .state_i (state),
    .total_o (idle_cyc_o)
  );

  assign pwr_state_o = state;

endmodule

// File: tb/dram_rank_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module dram_rank_pwr_ctrl_bench;

  localparam int NB = 2;
  localparam int TW = 16;
  localparam int XP = 3;
  localparam int XS = 7;
  localparam int HD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_open, rd_last, bank_closed, ref_wake, ref_start, ref_done;
  logic cmd_issue, queued, busy, drain;
  logic [NB-1:0]    bank_ld;
  logic [NB*TW-1:0] col_in, pre_in, act_in;
  logic [2:0]       pwr_state;
  logic             low_pwr, pd_enter, pd_exit, pd_open, sr_enter, sr_exit;
  logic [NB*TW-1:0] col_ok, pre_ok, act_ok;
  logic [TW-1:0]    idle_cyc;

  int n_chk = 0, n_fail = 0;
  int tcyc = 0, lp_cnt = 0, allow_m = 0;
  int m_col[NB], m_pre[NB], m_act[NB];

  always #10 clk = ~clk;

  dram_rank_pwr_ctrl #(
    .NUM_BANKS(NB), .TW(TW), .T_XP(XP), .T_XS(XS), .HOLD_CYC(HD)
  ) u_dram_rank_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .row_open_i(row_open), .rd_last_i(rd_last), .bank_closed_i(bank_closed),
    .ref_wake_i(ref_wake), .ref_start_i(ref_start), .ref_done_i(ref_done),
    .cmd_issue_i(cmd_issue), .queued_i(queued), .busy_i(busy), .drain_i(drain),
    .bank_ld_i(bank_ld), .col_in_i(col_in), .pre_in_i(pre_in), .act_in_i(act_in),
    .pwr_state_o(pwr_state), .low_pwr_o(low_pwr),
    .pd_enter_o(pd_enter), .pd_exit_o(pd_exit), .pd_open_o(pd_open),
    .sr_enter_o(sr_enter), .sr_exit_o(sr_exit),
    .col_ok_o(col_ok), .pre_ok_o(pre_ok), .act_ok_o(act_ok),
    .idle_cyc_o(idle_cyc)
  );

  always @(posedge clk) begin
    if (!rst_n) tcyc <= 0;
    else        tcyc <= tcyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && (pwr_state == 3'd2 || pwr_state == 3'd3 || pwr_state == 3'd5))
      lp_cnt <= lp_cnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    row_open = 0; rd_last = 0; bank_closed = 0; ref_wake = 0; ref_start = 0;
    ref_done = 0; cmd_issue = 0; queued = 0; busy = 0; drain = 0;
    bank_ld = '0; col_in = '0; pre_in = '0; act_in = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic mwake(input int dly);
    int wk;
    wk = (tcyc >= allow_m) ? tcyc : allow_m;
    for (int b = 0; b < NB; b++) begin
      if (m_col[b] < wk + dly) m_col[b] = wk + dly;
      if (m_pre[b] < wk + dly) m_pre[b] = wk + dly;
      if (m_act[b] < wk + dly) m_act[b] = wk + dly;
    end
  endtask

  task automatic chk_banks(input string req);
    for (int b = 0; b < NB; b++) begin
      chk(req, "col", int'(col_ok[b*TW +: TW]), m_col[b]);
      chk(req, "pre", int'(pre_ok[b*TW +: TW]), m_pre[b]);
      chk(req, "act", int'(act_ok[b*TW +: TW]), m_act[b]);
    end
  endtask

  task automatic mark_entry();
    allow_m = tcyc + HD;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr();
    for (int b = 0; b < NB; b++) begin m_col[b] = 0; m_pre[b] = 0; m_act[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "state", pwr_state, 0);
    chk("R1", "low", low_pwr, 0);
    chk("R1", "idle", idle_cyc, 0);
    chk("R1", "strobes", {pd_enter, pd_exit, sr_enter, sr_exit}, 0);
    chk_banks("R1");
    row_open = 1; tick();
    chk("R1", "open->ACT", pwr_state, 4);

    // R2 entry gated by readiness
    rd_last = 1; queued = 1; tick();
    chk("R2", "queued blocks", pwr_state, 4);
    chk("R2", "no strobe", pd_enter, 0);
    rd_last = 1; busy = 1; tick();
    chk("R2", "busy blocks", pwr_state, 4);
    rd_last = 1; mark_entry(); tick();
    chk("R2", "ACT->ACT_PDN", pwr_state, 5);
    chk("R5", "pd_enter", pd_enter, 1);
    chk("R5", "pd_open", pd_open, 1);
    chk("R5", "low", low_pwr, 1);

    // R7 R10 deferred wake right after entry
    cmd_issue = 1; mwake(XP); tick();
    chk("R10", "pd_exit", pd_exit, 1);
    chk("R10", "pd_open", pd_open, 1);
    chk("R10", "still low state", pwr_state, 5);
    chk("R5", "low cleared", low_pwr, 0);
    chk_banks("R7");
    tick();
    chk("R8", "ACT_PDN->ACT", pwr_state, 4);

    // R3 bank close
    bank_closed = 1; queued = 1; tick();
    chk("R3", "close busy->IDLE", pwr_state, 0);
    chk("R3", "no strobe", pd_enter, 0);
    tick();
    chk("R11", "idle total", idle_cyc, lp_cnt);
    chk("R11", "idle total value", idle_cyc, 2);
    row_open = 1; tick();
    bank_closed = 1; mark_entry(); tick();
    chk("R3", "close->PRE_PDN", pwr_state, 3);
    chk("R3", "pd_enter", pd_enter, 1);
    chk("R3", "pd_open", pd_open, 0);
    tick(); tick(); tick();
    chk("R5", "held low", low_pwr, 1);

    // R7 merge with a same-cycle load, refresh wake remembers PRE_PDN
    ref_wake = 1; bank_ld = 2'b10;
    col_in[TW +: TW] = 16'd1000; pre_in[TW +: TW] = 16'd5; act_in[TW +: TW] = 16'd5;
    m_col[1] = 1000; m_pre[1] = 5; m_act[1] = 5;
    mwake(XP); tick();
    chk("R10", "pd_exit pre", pd_exit, 1);
    chk("R10", "pd_open pre", pd_open, 0);
    chk_banks("R7");
    tick();
    chk("R8", "PRE_PDN->IDLE", pwr_state, 0);
    ref_start = 1; tick();
    chk("R1", "IDLE->REF", pwr_state, 1);
    ref_done = 1; mark_entry(); tick();
    chk("R9", "remembered PRE_PDN->SREF", pwr_state, 2);
    chk("R4", "sr_enter", sr_enter, 1);

    // R6 command issue has no effect in SREF
    cmd_issue = 1; tick();
    chk("R6", "SREF kept", pwr_state, 2);
    chk("R6", "no exit", {pd_exit, sr_exit}, 0);
    chk("R6", "low kept", low_pwr, 1);
    tick();
    queued = 1; mwake(XS); tick();
    chk("R10", "sr_exit", sr_exit, 1);
    chk_banks("R7");
    tick();
    chk("R8", "SREF->IDLE", pwr_state, 0);

    // R9 non-refresh wake clears memory
    ref_start = 1; tick();
    ref_done = 1; mark_entry(); tick();
    chk("R9", "cleared->PRE_PDN", pwr_state, 3);

    // R4 remembered PRE_PDN with queued work
    tick(); ref_wake = 1; mwake(XP); tick(); tick();
    ref_start = 1; tick();
    ref_done = 1; queued = 1; mark_entry(); tick();
    chk("R4", "queued->PRE_PDN", pwr_state, 3);

    // R6 drain forces SREF exit
    tick(); ref_wake = 1; mwake(XP); tick(); tick();
    ref_start = 1; tick();
    ref_done = 1; mark_entry(); tick();
    chk("R4", "->SREF", pwr_state, 2);
    tick(); drain = 1; mwake(XS); tick();
    chk("R6", "drain sr_exit", sr_exit, 1);
    tick();
    chk("R6", "drain->IDLE", pwr_state, 0);
    chk_banks("R7");

    // R4 R9 remembered ACT_PDN
    row_open = 1; tick();
    rd_last = 1; mark_entry(); tick();
    chk("R2", "ACT_PDN", pwr_state, 5);
    tick(); ref_wake = 1; mwake(XP); tick(); tick();
    chk("R8", "->ACT", pwr_state, 4);
    bank_closed = 1; queued = 1; tick();
    ref_start = 1; tick();
    ref_done = 1; mark_entry(); tick();
    chk("R4", "ACT_PDN memory->PRE_PDN", pwr_state, 3);
    chk("R4", "pd_open", pd_open, 0);

    // R4 no memory, not ready
    tick(); cmd_issue = 1; mwake(XP); tick(); tick();
    chk("R8", "->IDLE", pwr_state, 0);
    ref_start = 1; tick();
    ref_done = 1; busy = 1; tick();
    chk("R4", "not ready->IDLE", pwr_state, 0);
    chk("R4", "no strobe", pd_enter, 0);
    ref_start = 1; tick();
    ref_done = 1; mark_entry(); tick();
    chk("R4", "ready->PRE_PDN", pwr_state, 3);

    // R4 drain at refresh end
    tick(); ref_wake = 1; mwake(XP); tick(); tick();
    ref_start = 1; tick();
    ref_done = 1; drain = 1; tick();
    chk("R4", "drain->IDLE", pwr_state, 0);
    chk("R4", "low", low_pwr, 0);
    tick(); tick();
    chk("R11", "idle total end", idle_cyc, lp_cnt);
    chk_banks("R7");

    finish_run();
  end

endmodule